// File: doc/BRIEF.md
# Synchronous Transfer Rate Generator

This block paces byte strobes for a parallel bus that moves each byte with a request/acknowledge pair. A byte-wide rate parameter holds two fields: a period code that sets the minimum spacing between request strobes, and an offset that sets how many strobes may be outstanding without an acknowledge. When the offset field is zero the block works in asynchronous (interlocked) mode. Each request is then held high until the acknowledge arrives, and the next byte starts only after that.

Software or a sequencer writes the parameter register and then issues a transfer command that carries a byte count on a valid/ready port. The command port accepts a new command only while the block is idle: `cmd_ready` is low for the whole of a transfer, and a command presented during that time waits. The rate parameter is copied into a working set when a command is accepted, so a write to the register during a transfer has no effect until the next command. When every requested byte has been strobed and every strobe has been acknowledged, the block pulses `xfer_done` for one cycle and returns to idle.

Top module: `sync_rate_gen`

## Requirements
- R1: After reset `strobe_req` and `xfer_done` are low, `cmd_ready` is high, and the parameter register holds 0x02, which selects asynchronous mode.
- R2: The parameter register holds the offset in bits 7:4 and the period code in bits 3:0. An offset of 0 selects asynchronous mode and an offset from 1 to 15 selects synchronous mode.
- R3: In synchronous mode, consecutive request strobes (each one cycle high) are spaced by the coded period: 5 cycles for code 0 and 2*(code+2) cycles for codes 1 to 15, with a stall only as R4 allows.
- R4: In synchronous mode the block counts strobes that have not yet been acknowledged. No strobe is issued while that count equals the offset. An acknowledge while the count is zero is ignored.
- R5: In asynchronous mode the request stays high until a cycle in which the acknowledge is high, then stays low for exactly one cycle before the next byte's request.
- R6: A command of N bytes produces exactly N strobes (asynchronous: N request/acknowledge handshakes). A command of 0 bytes produces none.
- R7: `xfer_done` is a one-cycle pulse. It is raised in the cycle after the one in which all bytes are strobed and the outstanding count is zero.
- R8: A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low from acceptance until the done pulse. The parameter value held at acceptance applies to the whole command. The first strobe may appear in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| param_we | input | 1 | Write strobe for the rate parameter register |
| param_wdata | input | 8 | Rate parameter: offset in 7:4, period code in 3:0 |
| cmd_valid | input | 1 | Transfer command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_bytes | input | LEN_W | Byte count of the command |
| strobe_ack | input | 1 | Acknowledge from the far side |
| strobe_req | output | 1 | Request strobe |
| xfer_done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The bench drives stalls with long acknowledge latencies and small offsets. A design that compares the outstanding count off by one either overruns the offset or never fills it, and in both cases the strobe pattern departs from the reference. It measures strobe spacing at period codes 0, 1, 5 and 15, which catches the odd five-cycle case and any 2*(v+2) arithmetic slip. It sends acknowledges while idle, rewrites the parameter and pokes a new command in the middle of a transfer, and issues zero-length commands. A design that counted stray acknowledges, applied parameters early or accepted commands while busy would lose or add strobes, or report done at the wrong time.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int OFS_W      = 4;
  localparam int CODE_W     = 4;
  localparam int CFG_W      = OFS_W + CODE_W;
  localparam int PERIOD_MAX = 2 * ((1 << CODE_W) + 1);
  localparam int PACE_W     = $clog2(PERIOD_MAX + 1);
  localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(2);

  typedef struct packed {
    logic [OFS_W-1:0]  ofs;
    logic [CODE_W-1:0] code;
  } rate_cfg_t;

  function automatic logic [PACE_W-1:0] period_of(input logic [CODE_W-1:0] c);
    if (c == '0) return PACE_W'(5);
    else         return PACE_W'(2 * (int'(c) + 2));
  endfunction
endpackage

// File: rtl/srg_cfg_store.sv
module srg_cfg_store
  import srg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             capture,
  output rate_cfg_t        active
);
  rate_cfg_t held_q, act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= rate_cfg_t'(CFG_RESET);
      act_q  <= rate_cfg_t'(CFG_RESET);
    end else begin
      if (wr_en)   held_q <= rate_cfg_t'(wr_data);
      if (capture) act_q  <= held_q;
    end
  end

  assign active = act_q;

  AST_WORKING_SET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(act_q)); // R8
endmodule

// File: rtl/srg_pacer.sv
module srg_pacer
  import srg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  output logic              ready
);
  logic [PACE_W-1:0] pace_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              pace_q <= '0;
    else if (clear)          pace_q <= '0;
    else if (load)           pace_q <= period_of(code) - PACE_W'(1);
    else if (pace_q != '0)   pace_q <= pace_q - PACE_W'(1);
  end

  assign ready = (pace_q == '0);

  AST_SPACING_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> !ready); // R3
endmodule

// File: rtl/srg_window.sv
module srg_window
  import srg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             issue,
  input  logic             ack,
  input  logic [OFS_W-1:0] limit,
  output logic             full,
  output logic             empty
);
  logic [OFS_W-1:0] cnt_q;
  logic             dec;

  assign dec = ack && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else begin
      unique case ({issue, dec})
        2'b10:   cnt_q <= cnt_q + OFS_W'(1);
        2'b01:   cnt_q <= cnt_q - OFS_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign full  = (cnt_q == limit);
  assign empty = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> (cnt_q <= limit)); // R4
  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !issue) |=> empty); // R4
endmodule

// File: rtl/sync_rate_gen.sv
module sync_rate_gen
  import srg_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             param_we,
  input  logic [CFG_W-1:0] param_wdata,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [LEN_W-1:0] cmd_bytes,
  input  logic             strobe_ack,
  output logic             strobe_req,
  output logic             xfer_done
);
  rate_cfg_t        act;
  logic             run_q, gap_q, done_q;
  logic [LEN_W-1:0] rem_q;
  logic             accept, sync_mode, have_work, pace_ok, win_full, win_empty;
  logic             req_sync, req_async, byte_done, finish;

  assign accept    = cmd_valid && !run_q;
  assign cmd_ready = !run_q;
  assign sync_mode = (act.ofs != '0);
  assign have_work = run_q && (rem_q != '0);
  assign req_sync  = have_work && sync_mode && pace_ok && !win_full;
  assign req_async = have_work && !sync_mode && !gap_q;
  assign byte_done = sync_mode ? req_sync : (req_async && strobe_ack);
  assign finish    = run_q && (rem_q == '0) && win_empty;

  srg_cfg_store u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (param_we),
    .wr_data (param_wdata),
    .capture (accept),
    .active  (act)
  );

  srg_pacer u_pace (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .load  (req_sync),
    .code  (act.code),
    .ready (pace_ok)
  );

  srg_window u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .issue (req_sync),
    .ack   (strobe_ack),
    .limit (act.ofs),
    .full  (win_full),
    .empty (win_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rem_q  <= '0;
      gap_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      gap_q  <= req_async && strobe_ack;
      if (accept) begin
        run_q <= 1'b1;
        rem_q <= cmd_bytes;
      end else begin
        if (byte_done) rem_q <= rem_q - LEN_W'(1);
        if (finish)    run_q <= 1'b0;
      end
    end
  end

  assign strobe_req = sync_mode ? req_sync : req_async;
  assign xfer_done  = done_q;

  AST_ASYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_req && !sync_mode && !strobe_ack) |=> strobe_req); // R5
  AST_ASYNC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_req && !sync_mode && strobe_ack) |=> !strobe_req); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_req |-> !cmd_ready); // R8
endmodule

// File: tb/test_sync_rate_gen.sv
module test_sync_rate_gen;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             param_we = 1'b0;
  logic [7:0]       param_wdata = '0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [LEN_W-1:0] cmd_bytes = '0;
  logic             strobe_ack = 1'b0;
  logic             strobe_req;
  logic             xfer_done;

  sync_rate_gen #(.LEN_W(LEN_W)) i_sync_rate_gen (
    .clk(clk), .rst_n(rst_n), .param_we(param_we), .param_wdata(param_wdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_bytes(cmd_bytes),
    .strobe_ack(strobe_ack), .strobe_req(strobe_req), .xfer_done(xfer_done)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit live = 0;

  // behavioural reference state
  int m_param = 2, m_ofs = 0, m_code = 2, m_run = 0, m_rem = 0;
  int m_pace = 0, m_out = 0, m_gap = 0, m_done = 0;

  // stimulus control
  int bench_param = 2;
  bit cur_sync = 0;
  int lat = 1;
  bit stray = 0;
  int q[$];
  int hi = 0;
  int scount = 0;
  int chk_period = 0;
  bit have_prev = 0;
  int last_cyc = 0;

  function automatic int exp_period(input int code);
    return (code == 0) ? 5 : 2 * (code + 2);
  endfunction

  function automatic bit model_req();
    bit sy;
    bit can;
    sy  = (m_ofs != 0);
    can = (m_run != 0) && (m_rem > 0);
    if (sy) return can && (m_pace == 0) && (m_out < m_ofs);
    else    return can && (m_gap == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_param = 2; m_ofs = 0; m_code = 2; m_run = 0; m_rem = 0;
      m_pace = 0; m_out = 0; m_gap = 0; m_done = 0;
    end else begin
      bit rq, sy, acc, fin;
      rq  = model_req();
      sy  = (m_ofs != 0);
      acc = cmd_valid && (m_run == 0);
      fin = (m_run != 0) && (m_rem == 0) && (m_out == 0);
      m_done = fin;
      if (acc) begin
        m_run = 1; m_rem = int'(cmd_bytes);
        m_ofs = (m_param >> 4) & 15; m_code = m_param & 15;
        m_pace = 0; m_out = 0; m_gap = 0;
      end else begin
        if (sy) begin
          if (rq) m_pace = exp_period(m_code) - 1;
          else if (m_pace > 0) m_pace = m_pace - 1;
          if (strobe_ack && m_out > 0) m_out = m_out - 1;
          if (rq) begin m_out = m_out + 1; m_rem = m_rem - 1; end
          m_gap = 0;
        end else begin
          m_gap = (rq && strobe_ack) ? 1 : 0;
          if (rq && strobe_ack) m_rem = m_rem - 1;
        end
        if (fin) m_run = 0;
      end
      if (param_we) m_param = int'(param_wdata);
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (live) begin
      bit e_req, nack;
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog R7: actual still busy, expected done");
        finish_run();
      end
      e_req = model_req();
      n_cmp++;
      if (strobe_req !== e_req) begin
        n_bad++;
        $display("FAIL %s cyc %0d strobe_req: actual %b expected %b",
                 (m_ofs != 0) ? "R2 R4" : "R5", cyc, strobe_req, e_req);
      end
      n_cmp++;
      if (xfer_done !== (m_done != 0)) begin
        n_bad++;
        $display("FAIL R7 cyc %0d xfer_done: actual %b expected %0d", cyc, xfer_done, m_done);
      end
      n_cmp++;
      if (cmd_ready !== (m_run == 0)) begin
        n_bad++;
        $display("FAIL R8 cyc %0d cmd_ready: actual %b expected %0d", cyc, cmd_ready, m_run == 0);
      end
      // acknowledge responder
      nack = 0;
      if (stray) nack = 1;
      else if (cur_sync) begin
        if (strobe_req) q.push_back(cyc + lat);
        if (q.size() > 0 && q[0] <= cyc) begin
          void'(q.pop_front());
          nack = 1;
        end
      end else begin
        if (strobe_req) hi++; else hi = 0;
        nack = strobe_req && (hi > lat);
      end
      strobe_ack = nack;
      if (cur_sync ? strobe_req : (strobe_req && nack)) scount++;
      // R3 spacing
      if (strobe_req && chk_period > 0) begin
        if (have_prev) begin
          n_cmp++;
          if (cyc - last_cyc != chk_period) begin
            n_bad++;
            $display("FAIL R3 strobe spacing: actual %0d expected %0d", cyc - last_cyc, chk_period);
          end
        end
        have_prev = 1;
        last_cyc  = cyc;
      end
    end
  end

  task automatic write_param(input int v);
    @(negedge clk);
    param_we = 1'b1; param_wdata = 8'(v);
    @(negedge clk);
    param_we = 1'b0;
    bench_param = v;
  endtask

  // prm < 0 keeps the register; mid_prm >= 0 rewrites it during the transfer
  task automatic run_cmd(input int prm, input int len, input int latency,
                         input int mid_prm, input bit poke);
    if (prm >= 0) write_param(prm);
    @(negedge clk);
    cur_sync  = ((bench_param >> 4) & 15) != 0;
    lat       = latency;
    chk_period = (cur_sync && latency == 1) ? exp_period(bench_param & 15) : 0;
    have_prev = 0; scount = 0; hi = 0; q.delete();
    cmd_valid = 1'b1; cmd_bytes = LEN_W'(len);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    if (poke) begin
      cmd_bytes = LEN_W'(len + 7);
      repeat (3) @(negedge clk);
    end
    cmd_valid = 1'b0; cmd_bytes = '0;
    if (mid_prm >= 0) write_param(mid_prm);
    while (!xfer_done) @(negedge clk);
    n_cmp++;
    if (scount != len) begin
      n_bad++;
      $display("FAIL R6 strobe count: actual %0d expected %0d", scount, len);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    n_cmp += 3;
    if (strobe_req !== 1'b0) begin n_bad++; $display("FAIL R1 strobe_req: actual %b expected 0", strobe_req); end
    if (xfer_done !== 1'b0)  begin n_bad++; $display("FAIL R1 xfer_done: actual %b expected 0", xfer_done); end
    if (cmd_ready !== 1'b1)  begin n_bad++; $display("FAIL R1 cmd_ready: actual %b expected 1", cmd_ready); end
    live = 1;
    // R1 default parameter gives asynchronous handshakes
    run_cmd(-1, 3, 2, -1, 0);
    run_cmd(-1, 3, 0, -1, 0);
    // R3 spacing for several codes, R2 field layout
    run_cmd('h30, 6, 1, -1, 0);
    run_cmd('hF5, 4, 1, -1, 0);
    run_cmd('h1F, 3, 1, -1, 0);
    run_cmd('h91, 5, 1, -1, 0);
    // R4 stall on offset with slow acknowledge
    run_cmd('h21, 6, 20, -1, 0);
    run_cmd('h10, 4, 9, -1, 0);
    run_cmd('hF0, 20, 30, -1, 0);
    // R6 zero-length commands in both modes
    run_cmd('h32, 0, 1, -1, 0);
    run_cmd('h07, 0, 1, -1, 0);
    // R8 parameter rewrite and command poke during a transfer
    run_cmd('h41, 12, 3, 'h00, 1);
    run_cmd(-1, 3, 1, -1, 0);
    // R4 stray acknowledges while idle, then a one-deep window
    @(negedge clk); stray = 1;
    repeat (5) @(negedge clk);
    stray = 0;
    run_cmd('h11, 4, 2, -1, 0);
    // R5 slow async handshakes
    run_cmd('h0C, 4, 5, -1, 0);
    repeat (4) @(negedge clk);
    live = 0;
    @(negedge clk);
    finish_run();
  end
endmodule